// File: doc/BRIEF.md
# Three-Wire Group-Coded Register Loader

This block takes configuration words over a three-wire serial link (serial clock, serial data, enable) and stores each word in one of four holding latches: a control latch, a divider latch for each of two synthesizer channels, and a reference divider latch. The serial lines are assumed to be already synchronised to the system clock `clk`. Edges on them are found by comparing each line with its value one cycle earlier.

Every word goes least-significant bit first into one shared shift register, and the word ends with a two-bit group code. The group code picks the destination. Each field position is counted back from the most recent bit, so words of different lengths need no separate framing. On the rising edge of enable, the number of bits received is compared with the length that the group code demands. A word of the wrong length is dropped. A word of the right length is copied into its latch, and its fields appear as parallel outputs on the next clock.

The block also checks the power-up order. Both the reference word and the control word must be loaded before a divider word arrives. If a divider word comes first, the block flags an ordering error.

Top module: `grp_word_loader`

## Requirements
- R1: While `ser_en` is low, one bit of `ser_data` enters the shift register at each rising edge of `ser_clk`. Rising edges of `ser_clk` that occur while `ser_en` is high, including one in the same cycle as the enable rise, neither shift nor count.
- R2: The word is evaluated on a rising edge of `ser_en`. Let `{g1,g0}` be the last bit sent followed by the second-last bit sent. The destination is: 00 control, 01 channel-1 divider, 10 channel-2 divider, 11 reference. The outputs change one `clk` cycle after the cycle in which `ser_en` is first seen high.
- R3: Control and reference words must be exactly 14 bits long, and divider words exactly 19 bits long. A word of any other length is discarded, and every output keeps its value.
- R4: A rising edge of `ser_en` clears the bit count, so the next word is counted from zero whatever came before.
- R5: Control payload bits, numbered 1 to 12 in the order sent, are assigned as follows. Bit 1 drives `test_mode`. Bit 2 drives `cp_invert`. Bits 3 and 4 form `ch1_icode` as {bit3, bit4}. Bit 5 drives `ch1_stby`. Bits 6 and 7 form `ch2_icode` as {bit6, bit7}. Bit 8 drives `ch2_stby`. Bit 9 drives `ref_stby`. Bits 10 and 11 form `lock_sel` as {bit10, bit11}. Bit 12 drives `filt_sw`. Current codes mean 00 = 1600 µA, 01 = 200 µA, 10 = 400 µA and 11 = 800 µA.
- R6: A reference payload is 12 bits sent LSB first and forms `ref_count` = R. The output `ref_ratio` equals 2·R.
- R7: A divider payload is a 5-bit swallow value A sent LSB first, followed by a 12-bit main value B sent LSB first. The channel's ratio output equals 2·(32·B + A).
- R8: `seq_err` pulses for one cycle when a divider word is accepted before both a reference word and a control word have been accepted since reset. The divider word is still loaded.
- R9: During and after reset, with no word yet received, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, synchronised |
| ser_data | input | 1 | Serial data, synchronised |
| ser_en | input | 1 | Serial enable, synchronised; rising edge loads |
| test_mode | output | 1 | Control: test mode |
| cp_invert | output | 1 | Control: charge pump polarity |
| ch1_icode | output | 2 | Control: channel-1 current code |
| ch1_stby | output | 1 | Control: channel-1 standby |
| ch2_icode | output | 2 | Control: channel-2 current code |
| ch2_stby | output | 1 | Control: channel-2 standby |
| ref_stby | output | 1 | Control: reference divider standby |
| lock_sel | output | 2 | Control: lock-detect output select |
| filt_sw | output | 1 | Control: loop filter switch |
| ch1_swallow | output | 5 | Channel-1 swallow value A |
| ch1_main | output | 12 | Channel-1 main value B |
| ch1_ratio | output | 18 | Channel-1 division ratio 2·(32B+A) |
| ch2_swallow | output | 5 | Channel-2 swallow value A |
| ch2_main | output | 12 | Channel-2 main value B |
| ch2_ratio | output | 18 | Channel-2 division ratio 2·(32B+A) |
| ref_count | output | 12 | Reference value R |
| ref_ratio | output | 13 | Reference division ratio 2·R |
| seq_err | output | 1 | One-cycle pulse: divider word arrived out of order |

## Verification
Two events can fall in the same `clk` cycle: the enable rise, which loads the word and clears the bit count, and a serial clock rising edge. The bench provokes this by raising `ser_clk` with data 1 in the very cycle that raises `ser_en`. It then adds a further serial clock pulse while enable is still high. The case passes only if both the word just sent and the next correctly sized word are accepted, because any stray shifted or counted bit would make a length check fail. Random words of random group and occasionally wrong length are compared with a model that works from the payload values alone.

// File: rtl/grp_word_loader.sv
module grp_word_loader #(
  parameter int REF_W  = 12,
  parameter int SWL_W  = 5,
  parameter int MAIN_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_data,
  input  logic                      ser_en,
  output logic                      test_mode,
  output logic                      cp_invert,
  output logic [1:0]                ch1_icode,
  output logic                      ch1_stby,
  output logic [1:0]                ch2_icode,
  output logic                      ch2_stby,
  output logic                      ref_stby,
  output logic [1:0]                lock_sel,
  output logic                      filt_sw,
  output logic [SWL_W-1:0]          ch1_swallow,
  output logic [MAIN_W-1:0]         ch1_main,
  output logic [MAIN_W+SWL_W:0]     ch1_ratio,
  output logic [SWL_W-1:0]          ch2_swallow,
  output logic [MAIN_W-1:0]         ch2_main,
  output logic [MAIN_W+SWL_W:0]     ch2_ratio,
  output logic [REF_W-1:0]          ref_count,
  output logic [REF_W:0]            ref_ratio,
  output logic                      seq_err
);
  localparam int CTL_W   = 12;
  localparam int GC_W    = 2;
  localparam int CTL_LEN = CTL_W + GC_W;
  localparam int REF_LEN = REF_W + GC_W;
  localparam int DIV_LEN = SWL_W + MAIN_W + GC_W;
  localparam int MAX_A   = (CTL_LEN > REF_LEN) ? CTL_LEN : REF_LEN;
  localparam int SR_W    = (DIV_LEN > MAX_A) ? DIV_LEN : MAX_A;
  localparam int CNT_W   = $clog2(SR_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              ck_q, en_q;
  logic [SR_W-1:0]   sr;
  logic [CNT_W-1:0]  cnt;
  logic [CTL_W-1:0]  ctl_r, ctl_nx;
  logic [REF_W-1:0]  ref_nx;
  logic [SWL_W-1:0]  swl_nx;
  logic [MAIN_W-1:0] main_nx;
  logic              ref_ok, ctl_ok;
  logic              len_ok;
  logic [1:0]        gc;

  wire shift = ser_clk & ~ck_q & ~ser_en;
  wire load  = ser_en & ~en_q;
  assign gc  = {sr[0], sr[1]};

  always_comb begin
    for (int i = 0; i < CTL_W; i++)  ctl_nx[i]  = sr[CTL_LEN-1-i];
    for (int i = 0; i < REF_W; i++)  ref_nx[i]  = sr[REF_LEN-1-i];
    for (int i = 0; i < SWL_W; i++)  swl_nx[i]  = sr[DIV_LEN-1-i];
    for (int i = 0; i < MAIN_W; i++) main_nx[i] = sr[DIV_LEN-1-SWL_W-i];
    case (gc)
      2'b00:   len_ok = (cnt == CNT_W'(CTL_LEN));
      2'b11:   len_ok = (cnt == CNT_W'(REF_LEN));
      default: len_ok = (cnt == CNT_W'(DIV_LEN));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= 1'b0;
      en_q <= 1'b0;
      sr   <= '0;
      cnt  <= '0;
    end else begin
      ck_q <= ser_clk;
      en_q <= ser_en;
      if (load)
        cnt <= '0;
      else if (shift) begin
        sr <= {sr[SR_W-2:0], ser_data};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_r       <= '0;
      ch1_swallow <= '0;
      ch1_main    <= '0;
      ch2_swallow <= '0;
      ch2_main    <= '0;
      ref_count   <= '0;
      ref_ok      <= 1'b0;
      ctl_ok      <= 1'b0;
      seq_err     <= 1'b0;
    end else begin
      seq_err <= 1'b0;
      if (load && len_ok) begin
        case (gc)
          2'b00: begin
            ctl_r  <= ctl_nx;
            ctl_ok <= 1'b1;
          end
          2'b01: begin
            ch1_swallow <= swl_nx;
            ch1_main    <= main_nx;
            seq_err     <= ~(ref_ok & ctl_ok);
          end
          2'b10: begin
            ch2_swallow <= swl_nx;
            ch2_main    <= main_nx;
            seq_err     <= ~(ref_ok & ctl_ok);
          end
          default: begin
            ref_count <= ref_nx;
            ref_ok    <= 1'b1;
          end
        endcase
      end
    end
  end

  assign test_mode = ctl_r[0];
  assign cp_invert = ctl_r[1];
  assign ch1_icode = {ctl_r[2], ctl_r[3]};
  assign ch1_stby  = ctl_r[4];
  assign ch2_icode = {ctl_r[5], ctl_r[6]};
  assign ch2_stby  = ctl_r[7];
  assign ref_stby  = ctl_r[8];
  assign lock_sel  = {ctl_r[9], ctl_r[10]};
  assign filt_sw   = ctl_r[11];

  assign ch1_ratio = {ch1_main, ch1_swallow, 1'b0};
  assign ch2_ratio = {ch2_main, ch2_swallow, 1'b0};
  assign ref_ratio = {ref_count, 1'b0};
endmodule

// File: rtl/grp_word_loader_chk.sv
module grp_word_loader_chk #(
  parameter int SR_W  = 19,
  parameter int CNT_W = 6,
  parameter int REF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_en,
  input logic             en_q,
  input logic [SR_W-1:0]  sr,
  input logic [CNT_W-1:0] cnt,
  input logic [REF_W-1:0] ref_count,
  input logic             ref_ok,
  input logic             ctl_ok,
  input logic             seq_err
);
  // R1
  hold_while_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |=> $stable(sr));

  // R4
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !en_q) |=> (cnt == '0));

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_en && !en_q) |=> $stable(ref_count));

  // R8
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> !$past(ref_ok && ctl_ok));

  // R8
  seq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err);
endmodule

bind grp_word_loader grp_word_loader_chk #(
  .SR_W(SR_W), .CNT_W(CNT_W), .REF_W(REF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .en_q(en_q), .sr(sr),
  .cnt(cnt), .ref_count(ref_count), .ref_ok(ref_ok), .ctl_ok(ctl_ok),
  .seq_err(seq_err)
);

// File: tb/test_grp_word_loader.sv
module test_grp_word_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdat = 1'b0, sen = 1'b0;
  logic test_mode, cp_invert, ch1_stby, ch2_stby, ref_stby, filt_sw, seq_err;
  logic [1:0] ch1_icode, ch2_icode, lock_sel;
  logic [4:0] ch1_swallow, ch2_swallow;
  logic [11:0] ch1_main, ch2_main, ref_count;
  logic [17:0] ch1_ratio, ch2_ratio;
  logic [12:0] ref_ratio;

  grp_word_loader i_grp_word_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(sck), .ser_data(sdat), .ser_en(sen),
    .test_mode(test_mode), .cp_invert(cp_invert), .ch1_icode(ch1_icode),
    .ch1_stby(ch1_stby), .ch2_icode(ch2_icode), .ch2_stby(ch2_stby),
    .ref_stby(ref_stby), .lock_sel(lock_sel), .filt_sw(filt_sw),
    .ch1_swallow(ch1_swallow), .ch1_main(ch1_main), .ch1_ratio(ch1_ratio),
    .ch2_swallow(ch2_swallow), .ch2_main(ch2_main), .ch2_ratio(ch2_ratio),
    .ref_count(ref_count), .ref_ratio(ref_ratio), .seq_err(seq_err)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, seq_seen = 0, e_seq = 0;
  logic [11:0] e_ctl = '0, e_ref = '0;
  logic [4:0]  e_c1a = '0, e_c2a = '0;
  logic [11:0] e_c1b = '0, e_c2b = '0;
  bit e_refok = 0, e_ctlok = 0;

  always @(posedge clk) if (rst_n && seq_err) seq_seen++;

  function automatic int exp_ratio(input int a, input int b);
    return 2 * (32 * b + a);
  endfunction

  function automatic int cur_ua(input logic [1:0] c);
    case (c)
      2'b00: return 1600;
      2'b01: return 200;
      2'b10: return 400;
      default: return 800;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [11:0] ctl_act();
    return {filt_sw, lock_sel[0], lock_sel[1], ref_stby, ch2_stby,
            ch2_icode[0], ch2_icode[1], ch1_stby, ch1_icode[0], ch1_icode[1],
            cp_invert, test_mode};
  endfunction

  task automatic check_all(input string ctx);
    chk({ctx, " R5 control"}, int'(ctl_act()), int'(e_ctl));
    chk({ctx, " R6 ref"}, int'(ref_count), int'(e_ref));
    chk({ctx, " R6 ref ratio"}, int'(ref_ratio), 2 * int'(e_ref));
    chk({ctx, " R7 ch1 ratio"}, int'(ch1_ratio), exp_ratio(int'(e_c1a), int'(e_c1b)));
    chk({ctx, " R7 ch2 ratio"}, int'(ch2_ratio), exp_ratio(int'(e_c2a), int'(e_c2b)));
    chk({ctx, " R7 ch1 A"}, int'(ch1_swallow), int'(e_c1a));
    chk({ctx, " R7 ch2 B"}, int'(ch2_main), int'(e_c2b));
    chk({ctx, " R8 seq_err count"}, seq_seen, e_seq);
  endtask

  task automatic send(input logic [19:0] p, input int plen, input logic [1:0] gc,
                      input bit edge_case);
    bit ok;
    sen = 1'b0; sck = 1'b0; tick(1);
    for (int i = 0; i < plen + 2; i++) begin
      sdat = (i < plen) ? p[i] : ((i == plen) ? gc[0] : gc[1]);
      sck = 1'b0; tick(2);
      sck = 1'b1; tick(2);
    end
    sck = 1'b0; tick(1);
    if (edge_case) begin sck = 1'b1; sdat = 1'b1; end
    sen = 1'b1; tick(1);
    if (edge_case) begin sck = 1'b0; tick(1); sck = 1'b1; tick(1); sck = 1'b0; end
    tick(1);
    sen = 1'b0; tick(2);
    ok = (gc == 2'b00 || gc == 2'b11) ? (plen == 12) : (plen == 17);
    if (ok) begin
      case (gc)
        2'b00: begin e_ctl = p[11:0]; e_ctlok = 1; end
        2'b11: begin e_ref = p[11:0]; e_refok = 1; end
        2'b01: begin e_c1a = p[4:0]; e_c1b = p[16:5]; if (!(e_refok && e_ctlok)) e_seq++; end
        default: begin e_c2a = p[4:0]; e_c2b = p[16:5]; if (!(e_refok && e_ctlok)) e_seq++; end
      endcase
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3);
    chk("R9 reset control", int'(ctl_act()), 0);
    chk("R9 reset ref_ratio", int'(ref_ratio), 0);
    chk("R9 reset ch1_ratio", int'(ch1_ratio), 0);
    chk("R9 reset seq_err", int'(seq_err), 0);
    rst_n = 1'b1; tick(2);
    check_all("R9 after reset");

    send({3'b0, 12'd566, 5'd8}, 17, 2'b01, 0);
    check_all("R8 divider before setup");
    chk("R7 ch1 ratio 453MHz case", int'(ch1_ratio), 36240);

    send(20'd850, 12, 2'b11, 0);
    chk("R6 ref ratio 1700", int'(ref_ratio), 1700);
    send(20'h0_0A5C, 12, 2'b00, 0);
    check_all("R5 control directed");
    chk("R5 ch1 current uA", cur_ua(ch1_icode), cur_ua({e_ctl[2], e_ctl[3]}));

    send({3'b0, 12'd578, 5'd20}, 17, 2'b10, 0);
    chk("R7 ch2 ratio 462.9MHz case", int'(ch2_ratio), 37032);
    check_all("R8 ordered divider");

    send(20'hFFF, 11, 2'b00, 0);
    check_all("R3 short control");
    send(20'hFFFFF, 18, 2'b01, 0);
    check_all("R3 long divider");
    send(20'hFFF, 13, 2'b11, 0);
    check_all("R3 long reference");

    send(20'd1234, 12, 2'b11, 1);
    check_all("R1 clock at enable rise");
    send({3'b0, 12'd4095, 5'd31}, 17, 2'b01, 0);
    check_all("R4 count cleared after enable");

    for (int n = 0; n < 300; n++) begin
      logic [19:0] p = 20'($urandom);
      logic [1:0]  gc = 2'($urandom);
      int base = (gc == 2'b00 || gc == 2'b11) ? 12 : 17;
      int r = int'($urandom_range(0, 19));
      int plen = (r == 0) ? base - 1 : ((r == 1) ? base + 1 : base);
      send(p, plen, gc, ($urandom_range(0, 7) == 0));
      check_all((plen == base) ? "R2 random word" : "R3 random bad length");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule